// File: doc/BRIEF.md
# Free-Running Reference Counter with Coherent Halfword Reads

This peripheral keeps a 32-bit up-counter that advances once per pulse of a slow reference tick (nominally near 32 kHz), delivered as a one-cycle enable in the bus clock domain. Software uses the count as a steady time base. It reads the count through a simple synchronous register bus, either as one word or as two 16-bit halves.

A 16-bit bus cannot read a 32-bit value in one access, and the counter may advance between the two halves. To prevent a torn value, a low-half read also copies the upper half of the same register into a holding latch. A later high-half read returns that held copy rather than the live bits. A split pair of reads therefore always rebuilds one count instant.

The block also has a small settings register that keeps only two of the written bits. Any access the block cannot serve raises the error flag. This covers narrow accesses, writes to read-only or unmapped locations, unmapped or misaligned reads, and simultaneous read and write.

Top module: `sync_counter_periph`

## Requirements
- R1: Reset clears the settings register and the halfword latch to zero and loads the counter with `CNT_RESET` (default 0). While idle, read data and error are zero.
- R2: Each cycle with `tick_i` high advances the counter by exactly one, and 0xFFFFFFFF wraps to 0. Without a tick the count holds.
- R3: Read data and error are registered and appear in the cycle after the strobe. A read in the same cycle as a tick returns the count from before the increment. Cycles with no strobe give zero data and no error.
- R4: A word read (size code 2) at byte offset 0x04 returns the settings register. A word read at 0x10 returns the counter.
- R5: A halfword or word write to exactly offset 0x04 stores the written value ANDed with 0x0000000C. All other bits read back as zero.
- R6: A halfword read (size code 1) with address bits 1:0 equal to 00 returns the low 16 bits of the register at that word offset (0x04 or 0x10) in bits 15:0, with zeros above. The same read copies that register's upper 16 bits into the halfword latch.
- R7: A halfword read with address bits 1:0 equal to 10 returns the latch in bits 15:0, whatever the live upper half now holds, and raises no error. Only a successful low-half read changes the latch. Word reads, high-half reads and rejected accesses leave it unchanged.
- R8: Size code 0 (byte) and code 3 (reserved) are rejected for reads and writes. They set error, return zero data and change no state.
- R9: A write of any size to an address other than 0x04 sets error and changes nothing. In particular, the counter cannot be written.
- R10: A read at a word offset other than 0x04 or 0x10 (other than a high-half read) returns zero with error. A word read with address bits 1:0 not 00, or a halfword read with bit 0 set, is also rejected this way. A rejected low-half read leaves the latch unchanged.
- R11: Read and write strobes high in the same cycle set error, return zero and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow reference pulse |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| bus_err_o | output | 1 | Registered access error |

## Verification
A behavioural model tracks the count, the settings value and the latch, and every cycle is compared with it. The coherency test runs the counter up to 0xFFFEFFFF and does a low-half read in that same cycle while the tick carries into the upper half. A word read then shows the live upper half has moved, and the following high-half read must still return the old value, which proves the latch is used. Reads at the 0xFFFFFFFF wrap, settings writes with all ones (to check the mask), and each kind of rejected access each have an observable effect that differs between a correct and a faulty design. For the rejected cases, a high-half read or a settings read afterwards shows that no state changed.

// File: rtl/sync_ctr_pkg.sv
package sync_ctr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // classification of one bus cycle
    typedef struct packed {
        logic rd_ok;     // read is served
        logic wr_ok;     // write to settings register is accepted
        logic bad;       // access rejected, error flag
        logic pick_cfg;  // addressed word is the settings register
        logic is_half;   // 16-bit access
        logic is_high;   // upper half selected
    } acc_dec_t;

endpackage

// File: rtl/sync_ctr_count.sv
module sync_ctr_count #(
    parameter int                CNT_W     = 32,
    parameter logic [CNT_W-1:0]  CNT_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
            cnt_d.value = cnt_q.value + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.value <= CNT_RESET;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.value;

endmodule

// File: rtl/sync_ctr_cfg.sv
module sync_ctr_cfg #(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] CFG_MASK = 'h0000000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cfg_o
);

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.bits = wdata_i & CFG_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.bits <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q.bits;

endmodule

// File: rtl/sync_ctr_decode.sv
module sync_ctr_decode
    import sync_ctr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CFG_OFF = 'h04,
    parameter int CNT_OFF = 'h10
) (
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output acc_dec_t          dec_o
);

    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFF);
    localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_OFF);

    logic [ADDR_W-1:0] word_off;
    logic              size_ok;
    logic              align_ok;
    logic              hit_cfg;
    logic              hit_cnt;
    logic              high_sel;
    logic              rd_only;
    logic              wr_only;

    always_comb begin
        word_off = {addr_i[ADDR_W-1:2], 2'b00};
        hit_cfg  = (word_off == CFG_A);
        hit_cnt  = (word_off == CNT_A);
        size_ok  = (size_i == SZ_HALF) || (size_i == SZ_WORD);
        align_ok = (size_i == SZ_WORD) ? (addr_i[1:0] == 2'b00) : !addr_i[0];
        high_sel = (size_i == SZ_HALF) && addr_i[1];
        rd_only  = rd_i && !wr_i;
        wr_only  = wr_i && !rd_i;

        dec_o          = '0;
        dec_o.pick_cfg = hit_cfg;
        dec_o.is_half  = (size_i == SZ_HALF);
        dec_o.is_high  = high_sel;
        dec_o.rd_ok    = rd_only && size_ok && align_ok && (high_sel || hit_cfg || hit_cnt);
        dec_o.wr_ok    = wr_only && size_ok && (addr_i == CFG_A);
        dec_o.bad      = (rd_i && wr_i)
                       || (rd_only && !dec_o.rd_ok)
                       || (wr_only && !dec_o.wr_ok);
    end

endmodule

// File: rtl/sync_counter_periph.sv
module sync_counter_periph
    import sync_ctr_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter int                CFG_OFF   = 'h04,
    parameter int                CNT_OFF   = 'h10,
    parameter logic [DATA_W-1:0] CFG_MASK  = 'h0000000C,
    parameter logic [DATA_W-1:0] CNT_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [1:0]        bus_size_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_err_o
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic [HALF_W-1:0] latch;
    } port_state_t;

    acc_dec_t          dec;
    logic [DATA_W-1:0] cnt_val;
    logic [DATA_W-1:0] cfg_val;
    logic [DATA_W-1:0] word_sel;
    logic [HALF_W-1:0] lat_val;
    port_state_t       st_d, st_q;

    sync_ctr_decode #(
        .ADDR_W  (ADDR_W),
        .CFG_OFF (CFG_OFF),
        .CNT_OFF (CNT_OFF)
    ) u_decode (
        .rd_i   (bus_rd_i),
        .wr_i   (bus_wr_i),
        .addr_i (bus_addr_i),
        .size_i (bus_size_i),
        .dec_o  (dec)
    );

    sync_ctr_count #(
        .CNT_W     (DATA_W),
        .CNT_RESET (CNT_RESET)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .count_o (cnt_val)
    );

    sync_ctr_cfg #(
        .DATA_W   (DATA_W),
        .CFG_MASK (CFG_MASK)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (dec.wr_ok),
        .wdata_i (bus_wdata_i),
        .cfg_o   (cfg_val)
    );

    always_comb begin
        word_sel = dec.pick_cfg ? cfg_val : cnt_val;

        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = dec.bad;

        if (dec.rd_ok) begin
            if (!dec.is_half) begin
                st_d.rdata = word_sel;
            end else if (dec.is_high) begin
                st_d.rdata = {{(DATA_W-HALF_W){1'b0}}, st_q.latch};
            end else begin
                st_d.rdata = {{(DATA_W-HALF_W){1'b0}}, word_sel[HALF_W-1:0]};
                st_d.latch = word_sel[DATA_W-1:HALF_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_val     = st_q.latch;
    assign bus_rdata_o = st_q.rdata;
    assign bus_err_o   = st_q.err;

endmodule

// File: rtl/sync_ctr_checks.sv
module sync_ctr_checks #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CFG_OFF = 'h04
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_i,
    input logic                bus_rd_i,
    input logic                bus_wr_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [1:0]          bus_size_i,
    input logic [DATA_W-1:0]   bus_rdata_o,
    input logic                bus_err_o,
    input logic [DATA_W-1:0]   cnt_val,
    input logic [DATA_W/2-1:0] lat_val
);

    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_val == $past(cnt_val) + 1'b1);

    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> cnt_val == $past(cnt_val));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_i && !bus_wr_i) |=> (bus_rdata_o == '0) && !bus_err_o);

    a_r7_latch_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_i && !bus_wr_i && bus_size_i == 2'd1 && !bus_addr_i[1]) |=> $stable(lat_val));

    a_r7_high_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !bus_wr_i && bus_size_i == 2'd1 && bus_addr_i[1:0] == 2'b10)
        |=> (bus_rdata_o == DATA_W'($past(lat_val))) && !bus_err_o);

    a_r8_narrow_reject: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd_i || bus_wr_i) && bus_size_i == 2'd0) |=> bus_err_o && (bus_rdata_o == '0));

    a_r9_write_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_rd_i && bus_addr_i != ADDR_W'(CFG_OFF)) |=> bus_err_o);

    a_r11_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_wr_i) |=> bus_err_o && (bus_rdata_o == '0));

endmodule

bind sync_counter_periph sync_ctr_checks #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CFG_OFF (CFG_OFF)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_size_i  (bus_size_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_err_o   (bus_err_o),
    .cnt_val     (cnt_val),
    .lat_val     (lat_val)
);

// File: tb/test_sync_counter_periph.sv
module test_sync_counter_periph;

    localparam logic [31:0] START = 32'hFFFE_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [1:0]  bus_size_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        bus_err_o;

    always #2 clk = ~clk;

    sync_counter_periph #(.CNT_RESET(START)) i_sync_counter_periph (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_rd_i    (bus_rd_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_size_i  (bus_size_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .bus_err_o   (bus_err_o)
    );

    // reference model state
    logic [31:0] m_cnt = START;
    logic [31:0] m_cfg = '0;
    logic [15:0] m_lat = '0;
    logic [31:0] e_rdata = '0;
    logic        e_err = 1'b0;
    string       p_tag = "R1 reset idle";
    int          n_vec = 0;
    int          n_bad = 0;

    task automatic check_prev();
        n_vec++;
        if (bus_rdata_o !== e_rdata || bus_err_o !== e_err) begin
            n_bad++;
            $display("FAIL %s: rdata=%h err=%b, expected rdata=%h err=%b",
                     p_tag, bus_rdata_o, bus_err_o, e_rdata, e_err);
        end
    endtask

    task automatic apply(input bit r, input bit w, input logic [7:0] a,
                         input logic [1:0] sz, input logic [31:0] wd,
                         input bit tk, input string tag);
        logic [7:0]  woff;
        logic [31:0] wv;
        bit          mapped;
        @(negedge clk);
        check_prev();
        bus_rd_i = r; bus_wr_i = w; bus_addr_i = a; bus_size_i = sz;
        bus_wdata_i = wd; tick_i = tk;
        woff   = a & 8'hFC;
        mapped = (woff == 8'h04) || (woff == 8'h10);
        wv     = (woff == 8'h04) ? m_cfg : m_cnt;
        e_rdata = '0;
        e_err   = 1'b0;
        if (r && w) begin
            e_err = 1'b1;
        end else if (r) begin
            if (sz == 2'd2) begin
                if (a[1:0] != 2'b00 || !mapped) e_err = 1'b1;
                else e_rdata = wv;
            end else if (sz == 2'd1) begin
                if (a[0]) e_err = 1'b1;
                else if (a[1]) e_rdata = {16'h0, m_lat};
                else if (!mapped) e_err = 1'b1;
                else begin
                    e_rdata = {16'h0, wv[15:0]};
                    m_lat   = wv[31:16];
                end
            end else begin
                e_err = 1'b1;
            end
        end else if (w) begin
            if ((sz == 2'd1 || sz == 2'd2) && a == 8'h04) m_cfg = wd & 32'h0000_000C;
            else e_err = 1'b1;
        end
        if (tk) m_cnt = m_cnt + 32'd1;
        p_tag = tag;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, input bit tk, input string tag);
        apply(1'b1, 1'b0, a, sz, 32'h0, tk, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd, input string tag);
        apply(1'b0, 1'b1, a, sz, wd, 1'b0, tag);
    endtask

    task automatic idle(input bit tk, input string tag);
        apply(1'b0, 1'b0, 8'h0, 2'd0, 32'h0, tk, tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): run still busy, expected to be done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        idle(1'b0, "R1 idle after reset");
        rd(8'h10, 2'd2, 1'b0, "R1 counter reset value");
        rd(8'h04, 2'd2, 1'b0, "R1 settings reset value");
        rd(8'h12, 2'd1, 1'b0, "R1 latch reset value");

        // R2/R3: counting and same-cycle read
        for (int i = 0; i < 5; i++) idle(1'b1, "R2 tick idle");
        rd(8'h10, 2'd2, 1'b1, "R3 read with tick gives old value");
        rd(8'h10, 2'd2, 1'b0, "R2 count after ticks");

        // R6/R7: coherent split read across upper-half carry
        while (m_cnt != 32'hFFFE_FFFF) idle(1'b1, "R2 run to carry");
        rd(8'h10, 2'd1, 1'b1, "R6 low half at carry");
        rd(8'h10, 2'd2, 1'b0, "R4 word read shows live upper");
        rd(8'h12, 2'd1, 1'b0, "R7 high half returns latch");
        rd(8'h12, 2'd1, 1'b1, "R7 repeated high half");

        // R4/R5: settings register
        wr(8'h04, 2'd2, 32'hFFFF_FFFF, "R5 word write all ones");
        rd(8'h04, 2'd2, 1'b0, "R5 masked readback");
        wr(8'h04, 2'd1, 32'h0000_0004, "R5 halfword write");
        rd(8'h04, 2'd2, 1'b0, "R4 settings word read");
        rd(8'h04, 2'd1, 1'b0, "R6 low half of settings");
        rd(8'h06, 2'd1, 1'b0, "R6 high half after settings low read");

        // R8: narrow and reserved sizes
        rd(8'h10, 2'd1, 1'b0, "R6 reload latch from counter");
        rd(8'h10, 2'd0, 1'b0, "R8 byte read rejected");
        rd(8'h10, 2'd3, 1'b0, "R8 reserved size read rejected");
        wr(8'h04, 2'd0, 32'h0000_0008, "R8 byte write rejected");
        wr(8'h04, 2'd3, 32'h0000_0008, "R8 reserved size write rejected");
        rd(8'h04, 2'd2, 1'b0, "R8 settings unchanged");
        rd(8'h12, 2'd1, 1'b0, "R8 latch unchanged");

        // R9: illegal writes
        wr(8'h10, 2'd2, 32'h1234_5678, "R9 counter write rejected");
        wr(8'h06, 2'd1, 32'h0000_000C, "R9 write at 0x06 rejected");
        wr(8'h20, 2'd2, 32'h0000_000C, "R9 unmapped write rejected");
        rd(8'h10, 2'd2, 1'b0, "R9 counter unchanged");
        rd(8'h04, 2'd2, 1'b0, "R9 settings unchanged");

        // R10: unmapped and misaligned reads
        rd(8'h20, 2'd2, 1'b0, "R10 unmapped word read");
        rd(8'h20, 2'd1, 1'b1, "R10 unmapped low half read");
        rd(8'h12, 2'd1, 1'b0, "R10 latch kept after rejected low read");
        rd(8'h12, 2'd2, 1'b0, "R10 misaligned word read");
        rd(8'h11, 2'd1, 1'b0, "R10 odd halfword read");

        // R11: both strobes
        apply(1'b1, 1'b1, 8'h04, 2'd2, 32'h0000_0008, 1'b0, "R11 both strobes");
        rd(8'h04, 2'd2, 1'b0, "R11 settings unchanged");

        // R2: wrap through 0xFFFFFFFF
        while (m_cnt != 32'hFFFF_FFFE) idle(1'b1, "R2 run to wrap");
        rd(8'h10, 2'd2, 1'b1, "R2 before wrap");
        rd(8'h10, 2'd2, 1'b1, "R2 at max");
        rd(8'h10, 2'd2, 1'b0, "R2 after wrap");
        idle(1'b0, "R3 idle quiet");

        @(negedge clk);
        check_prev();
        summary();
        $finish;
    end

endmodule